// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block moves data in both directions between an A port and a B port. Each direction has its own storage cell and its own set of controls. The cell can pass data through, hold it like a level latch, capture it on a port-clock rising edge, or capture it only when a clock enable is asserted. Everything runs on one system clock. The port clocks are plain inputs: they are sampled through a short synchroniser, and a rising edge is recognised when the synchronised sample changes from 0 to 1 between two system cycles.

The A side is push-pull. It has a data bus and a per-bit drive enable, and all bits are enabled together. The B side is open-drain. Its data output is always 0, and a bit's drive enable is raised only where that bit must be pulled low. A high is produced by releasing the line, so the external termination pulls it up. During reset nothing is driven.

Top module: `ubt_xcvr`

## Requirements
- R1: The block has two independent paths, each WIDTH bits wide (default 18). A-to-B storage responds only to `ab_le`, `ab_ce_n`, `ab_ck` and `a_in`. B-to-A storage responds only to `ba_le`, `ba_ce_n`, `ba_ck` and `b_in`. Activity on one path never changes the other path's stored value.
- R2: While a path's latch enable is 1, its stored value takes the input data at every system clock edge. The value is visible one cycle later.
- R3: While the latch enable is 0 and no qualifying edge occurs, the stored value is held. This applies whether the port clock is held static high or static low, and whatever the input data does.
- R4: While the latch enable is 0 and the active-low clock enable is 0, a recognised port-clock rise writes the input data into storage.
- R5: While the latch enable is 0 and the clock enable is 1, port-clock rises leave the stored value unchanged.
- R6: A port-clock rise first sampled high at system edge k is written into storage at edge k+SYNC_STAGES (default: k+2), using the data present at that edge. Each rise causes exactly one capture, because the recognised-edge pulse lasts a single cycle.
- R7: On the A side, `a_out` equals the B-to-A stored value. `a_oe` is all ones when `ba_oe_n` is 0 and all zeros when it is 1.
- R8: On the B side, `b_out` is always 0. `b_oe[i]` is 1 exactly when `ab_oe_n` is 0 and stored A-to-B bit i is 0, so a released line reads as 1.
- R9: A synchronous active-high `rst` clears both stored values to 0. While `rst` is 1, `a_oe` and `b_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | A-port data into the A-to-B path |
| b_in | input | WIDTH | B-port data into the B-to-A path |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_ck | input | 1 | A-to-B port clock (asynchronous, sampled) |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_ck | input | 1 | B-to-A port clock (asynchronous, sampled) |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| a_out | output | WIDTH | A-side data, push-pull |
| a_oe | output | WIDTH | A-side per-bit drive enable |
| b_out | output | WIDTH | B-side data, always 0 (open-drain) |
| b_oe | output | WIDTH | B-side per-bit pull-low enable |

## Verification
Some properties are checked every cycle:
- the storage update rule for following, capturing and holding;
- the single-cycle edge pulse;
- that a cell only captures on a recognised, enabled rise;
- that the B side never pulls a line whose stored bit is 1;
- that the A enables are uniform;
- that nothing drives during reset.

Other behaviour only the bench scenarios can show:
- the exact capture latency after a port-clock rise;
- that held data survives a static-high clock and input changes;
- that a rise is blocked when the clock enable is off;
- that the two directions are independent.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  typedef enum logic [1:0] {
    CELL_HOLD    = 2'd0,
    CELL_FOLLOW  = 2'd1,
    CELL_CAPTURE = 2'd2
  } cell_op_e;

  // A rise is a 0 sample followed by a 1 sample.
  function automatic logic rise_seen(input logic now_s, input logic was_s);
    return now_s & ~was_s;
  endfunction

  // Latch enable wins; otherwise only an enabled rise writes.
  function automatic cell_op_e choose_op(input logic le, input logic ce_n,
                                         input logic rise);
    if (le)                 return CELL_FOLLOW;
    else if (!ce_n && rise) return CELL_CAPTURE;
    else                    return CELL_HOLD;
  endfunction

  // Open-drain bit: pull low only when enabled and the bit is 0.
  function automatic logic od_pull(input logic oe_n, input logic bit_v);
    return ~oe_n & ~bit_v;
  endfunction

endpackage

// File: rtl/ubt_rise_sync.sv
module ubt_rise_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ck_async,
  output logic rise
);
  import ubt_pkg::*;

  logic [STAGES-1:0] chain;
  logic              last_q;
  logic              synced;

  assign synced = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain[0] <= ck_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last_q <= synced;
    end
  end

  assign rise = rise_seen(synced, last_q);

  assert_rise_single_R6: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/ubt_cell.sv
module ubt_cell #(
  parameter int W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             le,
  input  logic             ce_n,
  input  logic             rise,
  input  logic [W-1:0]     d,
  output logic [W-1:0]     q,
  output ubt_pkg::cell_op_e op
);
  import ubt_pkg::*;

  assign op = choose_op(le, ce_n, rise);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else begin
      case (op)
        CELL_FOLLOW, CELL_CAPTURE: q <= d;
        default:                   q <= q;
      endcase
    end
  end

  assert_follow_R2: assert property (@(posedge clk) disable iff (rst)
    le |=> q == $past(d));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!le && !rise) |=> q == $past(q));
  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (!le && !ce_n && rise) |=> q == $past(d));
  assert_ce_block_R5: assert property (@(posedge clk) disable iff (rst)
    (!le && ce_n) |=> q == $past(q));
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> q == '0);

endmodule

// File: rtl/ubt_drive.sv
module ubt_drive #(
  parameter int W          = 18,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic         rst,
  input  logic         oe_n,
  input  logic [W-1:0] q,
  output logic [W-1:0] out,
  output logic [W-1:0] oe
);
  import ubt_pkg::*;

  generate
    if (OPEN_DRAIN) begin : g_od
      assign out = '0;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign oe[i] = ~rst & od_pull(oe_n, q[i]);
      end
    end else begin : g_pp
      assign out = q;
      assign oe  = (rst || oe_n) ? '0 : '1;
    end
  endgenerate

  always_comb begin
    if (OPEN_DRAIN) begin
      assert_od_never_high_R8: assert ((oe & q) == '0);
    end else begin
      assert_pp_uniform_R7: assert (oe == '0 || oe == '1);
    end
  end

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int WIDTH       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             ab_oe_n,
  input  logic             ab_le,
  input  logic             ab_ck,
  input  logic             ab_ce_n,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_ck,
  input  logic             ba_ce_n,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);
  import ubt_pkg::*;

  // Named internal events for the checks below.
  logic             ab_rise, ba_rise;
  logic [WIDTH-1:0] ab_q, ba_q;
  cell_op_e         ab_op, ba_op;

  ubt_rise_sync #(.STAGES(SYNC_STAGES)) u_ab_sync (
    .clk(clk), .rst(rst), .ck_async(ab_ck), .rise(ab_rise));
  ubt_rise_sync #(.STAGES(SYNC_STAGES)) u_ba_sync (
    .clk(clk), .rst(rst), .ck_async(ba_ck), .rise(ba_rise));

  ubt_cell #(.W(WIDTH)) u_ab_cell (
    .clk(clk), .rst(rst), .le(ab_le), .ce_n(ab_ce_n), .rise(ab_rise),
    .d(a_in), .q(ab_q), .op(ab_op));
  ubt_cell #(.W(WIDTH)) u_ba_cell (
    .clk(clk), .rst(rst), .le(ba_le), .ce_n(ba_ce_n), .rise(ba_rise),
    .d(b_in), .q(ba_q), .op(ba_op));

  // B side: open-drain, driven from the A-to-B cell.
  ubt_drive #(.W(WIDTH), .OPEN_DRAIN(1'b1)) u_b_drv (
    .rst(rst), .oe_n(ab_oe_n), .q(ab_q), .out(b_out), .oe(b_oe));
  // A side: push-pull, driven from the B-to-A cell.
  ubt_drive #(.W(WIDTH), .OPEN_DRAIN(1'b0)) u_a_drv (
    .rst(rst), .oe_n(ba_oe_n), .q(ba_q), .out(a_out), .oe(a_oe));

  assert_ab_capture_qualified_R4: assert property (@(posedge clk) disable iff (rst)
    (ab_op == CELL_CAPTURE) |-> (ab_rise && !ab_ce_n && !ab_le));
  assert_ba_capture_qualified_R1: assert property (@(posedge clk) disable iff (rst)
    (ba_op == CELL_CAPTURE) |-> (ba_rise && !ba_ce_n && !ba_le));
  assert_quiet_in_reset_R9: assert property (@(posedge clk)
    rst |-> (a_oe == '0 && b_oe == '0));
  assert_b_disable_R8: assert property (@(posedge clk) disable iff (rst)
    ab_oe_n |-> b_oe == '0);

endmodule

// File: tb/sim_ubt_xcvr.sv
module sim_ubt_xcvr;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in;
  logic         ab_oe_n, ab_le, ab_ck, ab_ce_n;
  logic         ba_oe_n, ba_le, ba_ck, ba_ce_n;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic [W-1:0] b_line;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // Pulled-up open-drain bus as seen from outside.
  assign b_line = ~b_oe;

  ubt_xcvr u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_ck(ab_ck), .ab_ce_n(ab_ce_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ck(ba_ck), .ba_ce_n(ba_ce_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    ab_oe_n = 1'b0; ba_oe_n = 1'b0;
    #1;
    chk("R9 a_oe off in reset", a_oe, '0);
    chk("R9 b_oe off in reset", b_oe, '0);
    step(1); rst = 1'b0;
    step(1);
    chk("R9 a_out cleared", a_out, '0);
    chk("R9 b line low from cleared store", b_line, '0);
    chk("R8 b_out constant zero", b_out, '0);
    chk("R7 a_oe all on", a_oe, '1);
  endtask

  task automatic t_transparent;
    ab_le = 1'b1; a_in = 18'h2A5C3;
    step(1);
    chk("R2 follow first value", b_line, 18'h2A5C3);
    a_in = 18'h15A3C;
    step(1);
    chk("R2 follow second value", b_line, 18'h15A3C);
    chk("R8 pull only zero bits", b_oe, ~18'h15A3C);
  endtask

  task automatic t_latch_hold;
    ab_le = 1'b0;
    step(1);
    a_in = 18'h3FFFF;
    step(3);
    chk("R3 held with static low clock", b_line, 18'h15A3C);
  endtask

  task automatic t_capture;
    ab_ce_n = 1'b0; a_in = 18'h0F0F0; ab_ck = 1'b1;
    step(2);
    chk("R6 not yet captured", b_line, 18'h15A3C);
    step(1);
    chk("R4 captured on enabled rise", b_line, 18'h0F0F0);
    a_in = 18'h00001;
    step(4);
    chk("R3 held with static high clock", b_line, 18'h0F0F0);
    ab_ck = 1'b0;
    step(3);
    chk("R3 held after clock fall", b_line, 18'h0F0F0);
  endtask

  task automatic t_ce_block;
    ab_ce_n = 1'b1; a_in = 18'h12345; ab_ck = 1'b1;
    step(5);
    chk("R5 rise ignored with enable off", b_line, 18'h0F0F0);
    ab_ck = 1'b0;
    step(3);
  endtask

  task automatic t_b_disable;
    ab_oe_n = 1'b1;
    #1;
    chk("R8 b released when disabled", b_oe, '0);
    ab_oe_n = 1'b0;
    #1;
    chk("R8 b drives again", b_line, 18'h0F0F0);
  endtask

  task automatic t_reverse;
    ba_le = 1'b1; b_in = 18'h3C3C3;
    step(1);
    chk("R1 reverse follow", a_out, 18'h3C3C3);
    ba_le = 1'b0; ba_ce_n = 1'b0; b_in = 18'h11111; ba_ck = 1'b1;
    step(3);
    chk("R1 reverse capture", a_out, 18'h11111);
    chk("R1 forward path untouched", b_line, 18'h0F0F0);
    ba_oe_n = 1'b1;
    #1;
    chk("R7 a_oe off when disabled", a_oe, '0);
    ba_oe_n = 1'b0;
    #1;
    chk("R7 a_oe on when enabled", a_oe, '1);
  endtask

  task automatic t_mid_reset;
    rst = 1'b1;
    #1;
    chk("R9 a_oe off mid reset", a_oe, '0);
    chk("R9 b_oe off mid reset", b_oe, '0);
    step(1); rst = 1'b0; ba_ck = 1'b0;
    step(1);
    chk("R9 a store cleared", a_out, '0);
    chk("R9 b store cleared", b_line, '0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0;
    ab_oe_n = 1'b1; ab_le = 1'b0; ab_ck = 1'b0; ab_ce_n = 1'b1;
    ba_oe_n = 1'b1; ba_le = 1'b0; ba_ck = 1'b0; ba_ce_n = 1'b1;
    step(3);
    t_reset();
    t_transparent();
    t_latch_hold();
    t_capture();
    t_ce_block();
    t_b_disable();
    t_reverse();
    t_mid_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule